// File: doc/BRIEF.md
# Overlapped Register Window File

This block is a windowed register file for a processor that passes procedure arguments in registers. The active procedure sees 32 logical registers. Eight are globals that every procedure shares. Eight are incoming arguments, eight are private locals and eight are outgoing arguments. Physically the windows form a ring. The outgoing group of one window is the same storage as the incoming group of the next window, so arguments and results cross a call boundary with no copying and no save or restore.

A current-window pointer selects the active window. Asserting `call_i` moves the pointer one window forward and asserting `ret_i` moves it one window back. The block counts how many windows are open. A call that would reuse a window still holding live data raises `overflow_o`. A return from the first window raises `underflow_o`. In both cases the pointer stays where it is. Spilling windows to memory is left to the surrounding logic.

The block has two combinational read ports and one write port that writes on the clock edge. Reads and the write both translate logical numbers through the pointer value that holds during the cycle, before any call or return in that cycle takes effect.

Top module: `orw_regfile`

## Requirements
- R1: After reset the window pointer `cwp_o` is 0, both flags are low and every register reads as 0.
- R2: Logical registers 0..7 are globals. A value written to one of them in any window reads back unchanged in every other window.
- R3: A lone call made while all 4 windows are open (three calls deep) raises `overflow_o` in that same cycle and leaves `cwp_o` unchanged. A lone call made in any other state raises no flag.
- R4: A lone return made at the initial window (depth 0) raises `underflow_o` in that same cycle and leaves `cwp_o` unchanged.
- R5: An accepted lone call moves `cwp_o` to (cwp+1) mod 4 and an accepted lone return moves it to (cwp−1) mod 4, both at the next clock edge.
- R6: Logical registers 24..31 (outgoing k = r−24) of window p are the same storage as logical registers 8..15 (incoming k = r−8) of window p+1.
- R7: Logical registers 16..23 are locals. A write to one of them in window p does not change the value read at the same number in any other window.
- R8: A write lands at the clock edge. A read of the same register in the same cycle returns the old value.
- R9: A write issued in the same cycle as a call or a return uses the window that is active before the pointer moves. Reads in that cycle also use that window.
- R10: When call and return are asserted together, neither takes effect. The pointer does not move and neither flag is raised.
- R11: Read port B returns the same register contents as port A would for its own address, independently of port A.
- R12: Windowed storage is circular. The outgoing registers of window 3 are the incoming registers of window 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_i | input | 1 | Advance to the next window |
| ret_i | input | 1 | Go back to the previous window |
| we_i | input | 1 | Write enable |
| waddr_i | input | 5 | Logical write register |
| wdata_i | input | 16 | Write data |
| raddr_a_i | input | 5 | Logical read register, port A |
| raddr_b_i | input | 5 | Logical read register, port B |
| rdata_a_o | output | 16 | Read data, port A |
| rdata_b_o | output | 16 | Read data, port B |
| cwp_o | output | 2 | Current window pointer |
| overflow_o | output | 1 | Call refused: no free window |
| underflow_o | output | 1 | Return refused: at initial window |

## Verification
Directed sequences exercise each register class in turn.
- Writing a global in one window and reading it in another separates the global mapping from the windowed one.
- Writing an outgoing register and reading the matching incoming one after a call shows the overlap.
- Returning to a window and reading a local written elsewhere shows that locals stay private.
- Walking up to window 3 and back to window 0 tests the wrap of the ring.

Cycles that combine a write or a read with a call or a return separate the pre-move pointer from the post-move pointer. Calls at full depth, returns at depth zero and simultaneous call and return separate the refusal paths from ordinary pointer steps. Long random runs of mixed traffic then compare every read against a model that places each register its own way.

// File: rtl/orw_pkg.sv
package orw_pkg;

  // Map a logical register number to a physical slot.
  // Globals sit above the windowed ring; windowed numbers start at the
  // window base and wrap around the ring.
  function automatic int unsigned orw_phys(input int unsigned ptr,
                                           input int unsigned lreg,
                                           input int unsigned g,
                                           input int unsigned l,
                                           input int unsigned c,
                                           input int unsigned w);
    int unsigned ring;
    ring = (l + c) * w;
    if (lreg < g) return ring + lreg;
    return (ptr * (l + c) + (lreg - g)) % ring;
  endfunction

endpackage

// File: rtl/orw_window_ctl.sv
module orw_window_ctl #(
  parameter int W    = 4,
  parameter int PTRW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            call_i,
  input  logic            ret_i,
  output logic [PTRW-1:0] cwp_o,
  output logic            call_ok_o,
  output logic            ret_ok_o,
  output logic            ovf_o,
  output logic            unf_o
);
  localparam logic [PTRW-1:0] LAST = PTRW'(W - 1);

  logic [PTRW-1:0] cwp_q, depth_q;
  logic            lone_call, lone_ret, ring_full, ring_empty;

  assign lone_call  = call_i & ~ret_i;
  assign lone_ret   = ret_i & ~call_i;
  assign ring_full  = (depth_q == LAST);
  assign ring_empty = (depth_q == '0);

  assign call_ok_o = lone_call & ~ring_full;
  assign ret_ok_o  = lone_ret & ~ring_empty;
  assign ovf_o     = lone_call & ring_full;
  assign unf_o     = lone_ret & ring_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q   <= '0;
      depth_q <= '0;
    end else if (call_ok_o) begin
      cwp_q   <= (cwp_q == LAST) ? '0 : cwp_q + 1'b1;
      depth_q <= depth_q + 1'b1;
    end else if (ret_ok_o) begin
      cwp_q   <= (cwp_q == '0) ? LAST : cwp_q - 1'b1;
      depth_q <= depth_q - 1'b1;
    end
  end

  assign cwp_o = cwp_q;
endmodule

// File: rtl/orw_addr_map.sv
module orw_addr_map #(
  parameter int G    = 8,
  parameter int L    = 8,
  parameter int C    = 8,
  parameter int W    = 4,
  parameter int LW   = 5,
  parameter int PW   = 7,
  parameter int PTRW = 2
) (
  input  logic [PTRW-1:0] cwp_i,
  input  logic [LW-1:0]   lreg_i,
  output logic [PW-1:0]   phys_o
);
  assign phys_o = PW'(orw_pkg::orw_phys(32'(cwp_i), 32'(lreg_i), G, L, C, W));
endmodule

// File: rtl/orw_storage.sv
module orw_storage #(
  parameter int DW    = 16,
  parameter int NPHYS = 72,
  parameter int PW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [PW-1:0] widx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [PW-1:0] ridx_a_i,
  input  logic [PW-1:0] ridx_b_i,
  output logic [DW-1:0] rdata_a_o,
  output logic [DW-1:0] rdata_b_o
);
  logic [DW-1:0] cells [NPHYS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) cells[i] <= '0;
    end else if (we_i) begin
      cells[widx_i] <= wdata_i;
    end
  end

  assign rdata_a_o = cells[ridx_a_i];
  assign rdata_b_o = cells[ridx_b_i];
endmodule

// File: rtl/orw_regfile.sv
module orw_regfile #(
  parameter int DATA_W = 16,
  parameter int G      = 8,
  parameter int L      = 8,
  parameter int C      = 8,
  parameter int W      = 4,
  parameter int NLOG   = G + L + 2 * C,
  parameter int LW     = $clog2(NLOG),
  parameter int PTRW   = $clog2(W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              we_i,
  input  logic [LW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LW-1:0]     raddr_a_i,
  input  logic [LW-1:0]     raddr_b_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o,
  output logic [PTRW-1:0]   cwp_o,
  output logic              overflow_o,
  output logic              underflow_o
);
  localparam int NRING = (L + C) * W;
  localparam int NPHYS = NRING + G;
  localparam int PW    = $clog2(NPHYS);
  localparam int NPORT = 3;

  logic [PTRW-1:0] cwp;
  logic            call_ok, ret_ok;
  logic [LW-1:0]   lreg [NPORT];
  logic [PW-1:0]   phys [NPORT];

  orw_window_ctl #(.W(W), .PTRW(PTRW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
    .cwp_o(cwp), .call_ok_o(call_ok), .ret_ok_o(ret_ok),
    .ovf_o(overflow_o), .unf_o(underflow_o)
  );

  assign lreg[0] = waddr_i;
  assign lreg[1] = raddr_a_i;
  assign lreg[2] = raddr_b_i;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    orw_addr_map #(
      .G(G), .L(L), .C(C), .W(W), .LW(LW), .PW(PW), .PTRW(PTRW)
    ) u_map (
      .cwp_i(cwp), .lreg_i(lreg[p]), .phys_o(phys[p])
    );
  end

  orw_storage #(.DW(DATA_W), .NPHYS(NPHYS), .PW(PW)) u_store (
    .clk(clk), .rst_n(rst_n), .we_i(we_i), .widx_i(phys[0]),
    .wdata_i(wdata_i), .ridx_a_i(phys[1]), .ridx_b_i(phys[2]),
    .rdata_a_o(rdata_a_o), .rdata_b_o(rdata_b_o)
  );

  assign cwp_o = cwp;
endmodule

// File: rtl/orw_regfile_chk.sv
module orw_regfile_chk #(
  parameter int W    = 4,
  parameter int PTRW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            call_i,
  input logic            ret_i,
  input logic [PTRW-1:0] cwp,
  input logic            call_ok,
  input logic            ret_ok,
  input logic            ovf,
  input logic            unf
);
  localparam logic [PTRW-1:0] LAST = PTRW'(W - 1);

  assert_call_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    call_ok |=> cwp == (($past(cwp) == LAST) ? '0 : $past(cwp) + 1'b1));

  assert_ret_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ok |=> cwp == (($past(cwp) == '0) ? LAST : $past(cwp) - 1'b1));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> cwp == $past(cwp));

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    unf |=> cwp == $past(cwp));

  assert_underflow_home_R4: assert property (@(posedge clk) disable iff (!rst_n)
    unf |-> cwp == '0);

  assert_pair_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && ret_i) |-> (!ovf && !unf && !call_ok && !ret_ok));

  assert_one_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf, unf, call_ok, ret_ok}));
endmodule

bind orw_regfile orw_regfile_chk #(.W(W), .PTRW(PTRW)) u_chk (
  .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
  .cwp(cwp_o), .call_ok(call_ok), .ret_ok(ret_ok),
  .ovf(overflow_o), .unf(underflow_o)
);

// File: tb/orw_regfile_tb.sv
module orw_regfile_tb;
  localparam int DW = 16, G = 8, L = 8, C = 8, W = 4;
  localparam int NLOG = G + L + 2 * C;
  localparam int SEG = L + C;
  localparam int NPH = SEG * W + G;

  logic clk = 0, rst_n = 0;
  logic call_i = 0, ret_i = 0, we_i = 0;
  logic [4:0] waddr_i = 0, raddr_a_i = 0, raddr_b_i = 0;
  logic [DW-1:0] wdata_i = 0, rdata_a_o, rdata_b_o;
  logic [1:0] cwp_o;
  logic overflow_o, underflow_o;

  orw_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i), .we_i(we_i),
    .waddr_i(waddr_i), .wdata_i(wdata_i), .raddr_a_i(raddr_a_i),
    .raddr_b_i(raddr_b_i), .rdata_a_o(rdata_a_o), .rdata_b_o(rdata_b_o),
    .cwp_o(cwp_o), .overflow_o(overflow_o), .underflow_o(underflow_o)
  );

  always #10 clk = ~clk;

  logic [DW-1:0] mdl [NPH];
  int mcwp = 0, mdepth = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Slot of a logical register, worked out per register class.
  function automatic int slot(int ptr, int r);
    if (r < G) return SEG * W + r;             // globals above the ring
    if (r < G + C) return ptr * SEG + (r - G);  // incoming
    if (r < G + C + L) return ptr * SEG + C + (r - G - C); // locals
    return ((ptr + 1) % W) * SEG + (r - G - C - L); // next window's incoming
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(string tag, bit c, bit r, bit we, int wa, int wd, int ra, int rb);
    bit eo, eu;
    @(negedge clk);
    call_i = c; ret_i = r; we_i = we;
    waddr_i = 5'(wa); wdata_i = DW'(wd); raddr_a_i = 5'(ra); raddr_b_i = 5'(rb);
    #5;
    eo = c && !r && (mdepth == W - 1);
    eu = r && !c && (mdepth == 0);
    chk(tag, int'(rdata_a_o), int'(mdl[slot(mcwp, ra)]));
    chk("R11", int'(rdata_b_o), int'(mdl[slot(mcwp, rb)]));
    chk("R3", int'(overflow_o), int'(eo));
    chk("R4", int'(underflow_o), int'(eu));
    chk("R5", int'(cwp_o), mcwp);
    if (we) mdl[slot(mcwp, wa)] = DW'(wd);
    if (c && !r && !eo) begin mcwp = (mcwp + 1) % W; mdepth++; end
    if (r && !c && !eu) begin mcwp = (mcwp + W - 1) % W; mdepth--; end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    int x;
    for (int i = 0; i < NPH; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    chk("R1", int'(cwp_o), 0);
    cyc("R1", 0, 0, 0, 0, 0, 0, 31);
    cyc("R1", 0, 0, 0, 0, 0, 16, 8);
    // R2 globals across windows
    cyc("R2", 0, 0, 1, 3, 16'hA5A5, 3, 3);
    cyc("R2", 1, 0, 0, 0, 0, 3, 3);
    cyc("R2", 0, 0, 0, 0, 0, 3, 7);
    // R6 outgoing of window 1 seen as incoming of window 2
    cyc("R6", 0, 0, 1, 24, 16'hBEEF, 24, 8);
    cyc("R6", 1, 0, 0, 0, 0, 8, 24);
    cyc("R6", 0, 0, 0, 0, 0, 8, 9);
    // R7 local in window 2 is private
    cyc("R7", 0, 0, 1, 16, 16'hC0DE, 16, 16);
    cyc("R7", 0, 1, 0, 0, 0, 16, 16);
    cyc("R7", 0, 0, 0, 0, 0, 16, 24);
    // R8 same-cycle write and read return old value
    cyc("R8", 0, 0, 1, 17, 16'h1111, 17, 17);
    cyc("R8", 0, 0, 0, 0, 0, 17, 17);
    // R9 write with a call uses pre-call window
    cyc("R9", 1, 0, 1, 25, 16'h2222, 25, 9);
    cyc("R9", 0, 0, 0, 0, 0, 9, 25);
    // R12 reach window 3, write outgoing, back to 0
    cyc("R12", 1, 0, 0, 0, 0, 8, 8);
    cyc("R12", 0, 0, 1, 31, 16'h3333, 31, 8);
    // R3 call at full depth
    cyc("R3", 1, 0, 0, 0, 0, 31, 15);
    cyc("R3", 0, 0, 0, 0, 0, 31, 15);
    // R10 call with return together
    cyc("R10", 1, 1, 0, 0, 0, 31, 8);
    cyc("R10", 0, 0, 0, 0, 0, 31, 8);
    cyc("R12", 0, 1, 0, 0, 0, 8, 8);
    cyc("R12", 0, 1, 0, 0, 0, 8, 8);
    cyc("R12", 0, 1, 0, 0, 0, 15, 15);
    cyc("R12", 0, 0, 0, 0, 0, 15, 8);
    // R4 return at initial window
    cyc("R4", 0, 1, 0, 0, 0, 15, 8);
    cyc("R4", 0, 0, 0, 0, 0, 15, 8);
    cyc("R10", 1, 1, 0, 0, 0, 0, 0);
    // random traffic
    seed = 32'h5EED;
    x = int'($urandom(seed));
    for (int n = 0; n < 2000; n++) begin
      int sel;
      sel = int'($urandom % 16);
      cyc("R5", sel == 0 || sel == 2, sel == 1 || sel == 2, $urandom % 2 == 1,
          int'($urandom % NLOG), int'($urandom % 65536),
          int'($urandom % NLOG), int'($urandom % NLOG));
    end
    cyc("R5", 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule